// File: doc/BRIEF.md
# One-Wire Bit Slot Engine

This block produces one bit time slot at a time on an open-drain one-wire bus. A host pulses `start_i` together with a 2-bit slot type. The engine then runs a write-one, write-zero or read slot. It pulls the line low through `drive_low_o` for the low time that belongs to the slot type, then lets the external pull-up take the line back high. It holds `busy_o` for the full slot plus the recovery time. A single-cycle `done_o` pulse ends each slot, and `bit_o` carries the slot's bit.

All slot timing is given in microseconds on input ports: the three low times, the read-valid threshold, the slot length and the recovery time. A prescaler counts `CLKS_PER_US` clock cycles to make each microsecond step. The step count always starts again from zero at the start of a slot.

For a read slot the result does not come from one fixed sample point. After the engine releases the line, it watches the synchronized line. The bit is 1 when the line is first seen high at a step count below the read-valid threshold. The bit is 0 when the line is first seen high at or after that threshold, or is not seen high at all before the watch closes.

Top module: `ow_bit_slot`

## Requirements
- R1: After reset `drive_low_o`, `busy_o`, `done_o` and `bit_o` are all 0.
- R2: When the engine is idle, a `start_i` pulse with type 2'b00 (write zero), 2'b01 (write one) or 2'b10 (read) raises `busy_o` and `drive_low_o` in the next cycle.
- R3: A write-one slot holds `drive_low_o` for exactly `t_low1_i` microseconds. A write-zero slot holds it for exactly `t_low0_i` microseconds. One microsecond is `CLKS_PER_US` clock cycles.
- R4: A read slot holds `drive_low_o` for exactly `t_lowr_i` microseconds. The length does not depend on what other devices do on the line.
- R5: Every slot keeps `busy_o` high for exactly `t_slot_i + t_rec_i` microseconds from its start. This holds for every slot type and every line behaviour, so the release time is the slot length minus the low time plus the recovery time.
- R6: A read returns 1 when the two-flop synchronized line is first seen high after release while the step count from slot start is below `t_rdv_i`. It returns 0 when the line is first seen high at or after `t_rdv_i`, or never before the watch closes at `t_rdv_i + 2` steps.
- R7: `done_o` is a one-cycle pulse in the first cycle after `busy_o` falls. With it `bit_o` shows the read result, or for a write slot the bit that was written, and `bit_o` holds that value until the next `done_o`.
- R8: A `start_i` that arrives while `busy_o` is high has no effect on the slot in progress. A `start_i` with type 2'b11 starts nothing and leaves `bit_o` unchanged.
- R9: `drive_low_o` is the only line output, and it is high only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for one slot |
| slot_type_i | input | 2 | 00 write zero, 01 write one, 10 read, 11 reserved |
| t_low1_i | input | TW | Low time of a write-one slot, in microseconds |
| t_low0_i | input | TW | Low time of a write-zero slot, in microseconds |
| t_lowr_i | input | TW | Low time of a read slot, in microseconds |
| t_rdv_i | input | TW | Read-valid threshold from slot start, in microseconds |
| t_slot_i | input | TW | Slot length, in microseconds |
| t_rec_i | input | TW | Recovery time after the slot, in microseconds |
| line_i | input | 1 | Sensed bus line, asynchronous |
| drive_low_o | output | 1 | Open-drain pull-down enable |
| busy_o | output | 1 | High for the slot plus recovery |
| done_o | output | 1 | One-cycle end-of-slot pulse |
| bit_o | output | 1 | Bit of the last completed slot |

## Verification
The bench drives reads against a responder that holds the line low for a set time. This includes the pair of hold times one microsecond below and exactly at the read-valid threshold. A design that compared against the threshold with the wrong inclusiveness, or that did not account for synchronizer latency, would flip one of those two bits. A design that shortened read slots when the line returned early would show a shorter busy time. Every slot is timed to the exact cycle, so an off-by-one prescaler or a release computed from the wrong low time shows up as a wrong count. Further checks issue a start in the middle of a slot and a start with the reserved type. A design that accepted either would restart or stretch the slot, or would change the held bit.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;
  typedef enum logic [1:0] {
    SLOT_W0  = 2'b00,
    SLOT_W1  = 2'b01,
    SLOT_RD  = 2'b10,
    SLOT_RSV = 2'b11
  } slot_kind_e;
endpackage

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
  parameter int CLKS_PER_US = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_US - 1);

  logic [PW-1:0] cnt_q;

  assign tick_o = en_i && !clear_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clear_i)     cnt_q <= '0;
    else if (en_i)        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // R5
  tick_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] sync_q;

  // idle bus is pulled high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], line_i};
  end

  assign line_o = sync_q[STAGES-1];
endmodule

// File: rtl/ow_slot_ctrl.sv
module ow_slot_ctrl
  import ow_slot_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    slot_type_i,
  input  logic [TW-1:0] t_low1_i,
  input  logic [TW-1:0] t_low0_i,
  input  logic [TW-1:0] t_lowr_i,
  input  logic [TW-1:0] t_rdv_i,
  input  logic [TW-1:0] t_slot_i,
  input  logic [TW-1:0] t_rec_i,
  input  logic          tick_i,
  input  logic          line_s_i,
  output logic          accept_o,
  output logic          drive_low_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          bit_o
);
  localparam int CW = TW + 1;

  slot_kind_e    kind_q;
  logic          busy_q, drive_q, done_q, bit_q, seen_q, rbit_q;
  logic [CW-1:0] us_q, us_nx, low_len, total, watch_end;

  assign accept_o  = start_i && !busy_q && (slot_type_i != SLOT_RSV);
  assign total     = CW'(t_slot_i) + CW'(t_rec_i);
  assign watch_end = CW'(t_rdv_i) + CW'(2);
  assign us_nx     = us_q + 1'b1;

  always_comb begin
    unique case (kind_q)
      SLOT_W1: low_len = CW'(t_low1_i);
      SLOT_W0: low_len = CW'(t_low0_i);
      default: low_len = CW'(t_lowr_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= SLOT_W0;
      busy_q  <= 1'b0;
      drive_q <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= 1'b0;
      seen_q  <= 1'b0;
      rbit_q  <= 1'b0;
      us_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        kind_q  <= slot_kind_e'(slot_type_i);
        busy_q  <= 1'b1;
        drive_q <= 1'b1;
        seen_q  <= 1'b0;
        rbit_q  <= 1'b0;
        us_q    <= '0;
      end else if (busy_q) begin
        // read watch: first high after release decides the bit
        if (kind_q == SLOT_RD && !drive_q && !seen_q && line_s_i &&
            us_q < watch_end) begin
          seen_q <= 1'b1;
          rbit_q <= (us_q < CW'(t_rdv_i));
        end
        if (tick_i) begin
          us_q <= us_nx;
          if (us_nx == low_len) drive_q <= 1'b0;
          if (us_nx >= total) begin
            busy_q  <= 1'b0;
            drive_q <= 1'b0;
            done_q  <= 1'b1;
            bit_q   <= (kind_q == SLOT_RD) ? rbit_q : (kind_q == SLOT_W1);
          end
        end
      end
    end
  end

  assign drive_low_o = drive_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign bit_o       = bit_q;

  // R9
  drive_in_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_low_o |-> busy_o);
  // R2
  drive_starts_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_low_o) |-> $rose(busy_o));
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R8
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && $past(busy_o)) |=> !$rose(drive_low_o));
  // R7
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(bit_o));
endmodule

// File: rtl/ow_bit_slot.sv
module ow_bit_slot #(
  parameter int CLKS_PER_US = 50,
  parameter int TW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    slot_type_i,
  input  logic [TW-1:0] t_low1_i,
  input  logic [TW-1:0] t_low0_i,
  input  logic [TW-1:0] t_lowr_i,
  input  logic [TW-1:0] t_rdv_i,
  input  logic [TW-1:0] t_slot_i,
  input  logic [TW-1:0] t_rec_i,
  input  logic          line_i,
  output logic          drive_low_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          bit_o
);
  logic tick, line_s, accept;

  ow_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .line_o (line_s)
  );

  ow_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .en_i    (busy_o),
    .tick_o  (tick)
  );

  ow_slot_ctrl #(.TW(TW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .slot_type_i (slot_type_i),
    .t_low1_i    (t_low1_i),
    .t_low0_i    (t_low0_i),
    .t_lowr_i    (t_lowr_i),
    .t_rdv_i     (t_rdv_i),
    .t_slot_i    (t_slot_i),
    .t_rec_i     (t_rec_i),
    .tick_i      (tick),
    .line_s_i    (line_s),
    .accept_o    (accept),
    .drive_low_o (drive_low_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .bit_o       (bit_o)
  );
endmodule

// File: tb/ow_bit_slot_bench.sv
module ow_bit_slot_bench;
  localparam int P  = 5;
  localparam int TW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] slot_type = 2'b00;
  logic [TW-1:0] t_low1 = 8'd6, t_low0 = 8'd60, t_lowr = 8'd2;
  logic [TW-1:0] t_rdv = 8'd15, t_slot = 8'd65, t_rec = 8'd5;
  logic drive_low, busy, done, bitv, line;
  logic drv_q = 1'b0;
  int   resp_us = 0, resp_cnt = 0;
  int   n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  // wired-AND bus: pull-up, master pull-down, responder pull-down
  assign line = !(drive_low || (resp_cnt != 0));

  always @(posedge clk) begin
    drv_q <= drive_low;
    if (drive_low && !drv_q && resp_us > 0) resp_cnt <= resp_us * P - 1;
    else if (resp_cnt != 0)                 resp_cnt <= resp_cnt - 1;
  end

  ow_bit_slot #(.CLKS_PER_US(P), .TW(TW)) u_ow_bit_slot (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .slot_type_i(slot_type),
    .t_low1_i(t_low1), .t_low0_i(t_low0), .t_lowr_i(t_lowr), .t_rdv_i(t_rdv),
    .t_slot_i(t_slot), .t_rec_i(t_rec), .line_i(line),
    .drive_low_o(drive_low), .busy_o(busy), .done_o(done), .bit_o(bitv)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // fields: type[18:17] resp_us[16:9] exp_bit[8] exp_low_us[7:0]
  localparam logic [18:0] VEC [8] = '{
    {2'b01, 8'd0,  1'b1, 8'd6},
    {2'b00, 8'd0,  1'b0, 8'd60},
    {2'b10, 8'd0,  1'b1, 8'd2},
    {2'b10, 8'd1,  1'b1, 8'd2},
    {2'b10, 8'd14, 1'b1, 8'd2},
    {2'b10, 8'd15, 1'b0, 8'd2},
    {2'b10, 8'd30, 1'b0, 8'd2},
    {2'b10, 8'd68, 1'b0, 8'd2}
  };

  task automatic run_slot(input logic [1:0] ty, input int r, input bit mid,
                          output int low_c, output int busy_c,
                          output logic dn, output logic b, output logic dn2);
    @(negedge clk);
    resp_us = r; slot_type = ty; start = 1'b1;
    @(negedge clk);
    start = 1'b0; low_c = 0; busy_c = 0;
    while (busy && busy_c < 5000) begin
      if (drive_low) low_c++;
      busy_c++;
      start = mid && (busy_c == 20);
      if (start) slot_type = 2'b01;
      @(negedge clk);
    end
    start = 1'b0;
    dn = done; b = bitv;
    @(negedge clk);
    dn2 = done;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lc, bc;
    logic dn, b, dn2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!drive_low && !busy && !done && !bitv, "R1 reset outputs", {drive_low, busy, done, bitv}, 0);

    for (int i = 0; i < 8; i++) begin
      run_slot(VEC[i][18:17], int'(VEC[i][16:9]), 1'b0, lc, bc, dn, b, dn2);
      // R3 R4 low time, R5 slot length, R6 R7 bit and done
      chk(lc == int'(VEC[i][7:0]) * P, $sformatf("R3/R4 low cycles vec%0d", i), lc, int'(VEC[i][7:0]) * P);
      chk(bc == 70 * P, $sformatf("R5 busy cycles vec%0d", i), bc, 70 * P);
      chk(dn && b == VEC[i][8], $sformatf("R6 R7 bit vec%0d", i), {dn, b}, {1'b1, VEC[i][8]});
      chk(!dn2, $sformatf("R7 done width vec%0d", i), dn2, 0);
      repeat (20) @(negedge clk);
    end

    // R2: start edge visible next cycle
    @(negedge clk);
    resp_us = 0; slot_type = 2'b01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && drive_low, "R2 start response", {busy, drive_low}, 3);
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);

    // R8: start during busy ignored
    run_slot(2'b00, 0, 1'b1, lc, bc, dn, b, dn2);
    chk(lc == 60 * P, "R8 mid-slot start low", lc, 60 * P);
    chk(bc == 70 * P, "R8 mid-slot start busy", bc, 70 * P);
    chk(dn && !b, "R8 mid-slot start bit", {dn, b}, 2);
    repeat (5) @(negedge clk);

    // R5 R3: programmed shorter timing
    t_slot = 8'd20; t_rec = 8'd3; t_low1 = 8'd4;
    run_slot(2'b01, 0, 1'b0, lc, bc, dn, b, dn2);
    chk(lc == 4 * P, "R3 short write-one low", lc, 4 * P);
    chk(bc == 23 * P, "R5 short slot busy", bc, 23 * P);
    chk(dn && b, "R7 write-one bit", {dn, b}, 3);
    repeat (5) @(negedge clk);

    // R8: reserved type starts nothing, bit held
    begin
      int bad = 0;
      @(negedge clk);
      slot_type = 2'b11; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 10; k++) begin
        if (busy || drive_low || done) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R8 reserved type idle", bad, 0);
      chk(bitv == 1'b1, "R8 reserved type bit held", bitv, 1);
    end

    // R9: idle after all slots
    chk(!drive_low && !busy, "R9 idle drive", {drive_low, busy}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule